// File: doc/BRIEF.md
# Video Controller Host Port Decoder

This block is the host side of a tile-based video controller. It takes a simple synchronous strobe bus with a 24-bit address and decides which of three ports an access targets: the data port, the control port or the beam-position counter. Data-port accesses are passed straight on to a separate transfer block. This block sees them only so that it can drop a half-written command.

Control-port writes do one of two jobs. They build a memory access command from two words, keeping a pending flag between the two writes. A single word that carries a register index writes the configuration file instead. The file holds the data-port auto-increment, the DMA enable bit, the tall-screen bit, and the DMA length, source, mode and wait flag. A control-port read returns a status word built from the beam position, the blanking state, the DMA-active command bit and the region input.

The assembled command code, the 16-bit memory address and the configuration values are outputs. The transfer block pulses `data_port_access` after each transfer, and the address then moves on by the auto-increment.

Top module: `vhp_host_port`

## Requirements
- R1: The port is chosen from the address masked with 0xC0001E. Address bits 23:22 must both be 1 and bit 4 must be 0. Bits 3:2 equal to 00 select the data port, 01 the control port, and bit 3 set selects the counter port. Bits 21:5 and bit 0 are ignored. Any other address selects nothing, and a read from it returns 0.
- R2: A counter-port read returns beam_v[7:0] in bits 15:8 and beam_hdot[8:1] in bits 7:0. A write to the counter port has no effect.
- R3: A control write whose bits 15:14 are not 2'b10, made while no command is pending, sets pending. It loads cmd_code[1:0] from data bits 15:14 and vram_addr[13:0] from data bits 13:0.
- R4: A control write made while pending clears pending. It loads cmd_code[5:2] from data bits 7:4 and vram_addr[15:14] from data bits 1:0, whatever its bits 15:14 hold.
- R5: A control write with bits 15:14 = 2'b10 and no command pending is a register write. The index is bits 12:8 and the value is bits 7:0. Bit 13 is ignored, and indices that are not mapped change nothing.
- R6: Register 0x0F is the 8-bit auto-increment. Each data_port_access pulse adds it to vram_addr, wrapping modulo 2^16.
- R7: Registers 0x13 and 0x14 are the DMA length, low byte then high byte. Registers 0x15, 0x16 and bits 5:0 of 0x17 are DMA source bits 7:0, 15:8 and 21:16. Bits 7:6 of 0x17 are the DMA mode, and a write to 0x17 sets dma_wait equal to value bit 7.
- R8: In register 0x01, bit 4 is the DMA enable and bit 3 selects 240 active lines rather than 224. While DMA is disabled, cmd_code[5] stays 0. Writing 0x01 with bit 4 clear forces it to 0, and a second command word loads 0 into it.
- R9: A second command word clears dma_wait when the DMA mode is 3. Under any other mode it leaves dma_wait unchanged.
- R10: A control read returns 0x3600 OR vblank<<3 OR hblank<<2 OR cmd_code[5]<<1 OR region_pal.
- R11: vblank is set when beam_v is at least the active line count (224 or 240). hblank is set when beam_h is at least 1280.
- R12: A control read, or any host read or write of the data port, clears pending. Data-port accesses are passed out on dport_rd and dport_wr in the same cycle. A data-port read returns dport_rdata.
- R13: Reset clears every register and the pending flag. All bus reads return their data in bus_rdata on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 24 | Host byte address |
| bus_wdata | input | 16 | Host write data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| dport_wr | output | 1 | Host write to the data port |
| dport_rd | output | 1 | Host read from the data port |
| dport_rdata | input | 16 | Data-port read value from the transfer block |
| data_port_access | input | 1 | Transfer done; advance the address |
| beam_v | input | 9 | Vertical beam counter |
| beam_hdot | input | 9 | Horizontal dot counter |
| beam_h | input | 11 | Horizontal raw counter used for blanking |
| region_pal | input | 1 | Region flag reported in status bit 0 |
| cmd_code | output | 6 | Assembled access command |
| vram_addr | output | 16 | Access address |
| auto_inc | output | 8 | Address step |
| dma_enable | output | 1 | DMA enable bit |
| display_tall | output | 1 | 240-line mode |
| dma_mode | output | 2 | DMA mode |
| dma_wait | output | 1 | DMA waiting for data |
| dma_length | output | 16 | DMA length |
| dma_source | output | 22 | DMA source |

## Verification
The assertions assume that the host never raises bus_rd and bus_wr in the same cycle. They also assume that a data_port_access pulse never arrives in the same cycle as a control-port write, since both could change the address at once. The bench drives one strobe at a time, each one cycle wide and set up on the falling edge. It keeps the transfer pulse apart from bus traffic, so every check stays inside these assumptions.

// File: rtl/vhp_pkg.sv
// Shared types and constants for the video host port.
// Assumes: register indices are 5 bits wide, taken from control word bits 12:8.
package vhp_pkg;
    typedef enum logic [1:0] {
        PORT_NONE,
        PORT_DATA,
        PORT_CTRL,
        PORT_HV
    } port_e;

    localparam int REG_IDX_W = 5;
    localparam logic [REG_IDX_W-1:0] REG_MODE2   = 5'h01;
    localparam logic [REG_IDX_W-1:0] REG_AUTOINC = 5'h0F;
    localparam logic [REG_IDX_W-1:0] REG_DMA_B0  = 5'h13;  // first of five consecutive DMA bytes
    localparam logic [REG_IDX_W-1:0] REG_DMA_TOP = 5'h17;
    localparam int DMA_BYTES = 5;
    localparam logic [1:0]  REG_WORD_TAG = 2'b10;
    localparam logic [15:0] STATUS_BASE  = 16'h3600;
endpackage

// File: rtl/vhp_port_decode.sv
// Address decoder: picks the data, control or counter port from a host address.
// Assumes: only bits 23:22 and 4:1 take part; bit 0 and bits 21:5 are mirrors.
module vhp_port_decode
    import vhp_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    output port_e             port
);
    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-3:5], addr[0]};

    // Select the port from the masked address.
    always_comb begin
        port = PORT_NONE;
        if (addr[ADDR_W-1:ADDR_W-2] == 2'b11 && !addr[4]) begin
            if (addr[3])
                port = PORT_HV;
            else if (addr[2])
                port = PORT_CTRL;
            else
                port = PORT_DATA;
        end
    end
endmodule

// File: rtl/vhp_cmd_latch.sv
// Command assembler: pairs two control words into a command code and an address,
// keeps the pending flag, and steps the address after each data transfer.
// Assumes: step_pulse never arrives in the same cycle as a control write.
module vhp_cmd_latch
    import vhp_pkg::*;
#(
    parameter int CMD_W  = 6,
    parameter int VADR_W = 16,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic              dport_hit,
    input  logic [15:0]       wdata,
    input  logic              step_pulse,
    input  logic [STEP_W-1:0] step,
    input  logic              dma_en,
    input  logic              dma_kill,
    output logic [CMD_W-1:0]  cmd,
    output logic [VADR_W-1:0] addr,
    output logic              pending,
    output logic              word2,
    output logic              reg_wr
);
    logic word1;

    // Classify the control write.
    always_comb begin
        word1  = ctl_wr && !pending && (wdata[15:14] != REG_WORD_TAG);
        word2  = ctl_wr && pending;
        reg_wr = ctl_wr && !pending && (wdata[15:14] == REG_WORD_TAG);
    end

    // Pending flag between the two command words.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (word1)
            pending <= 1'b1;
        else if (word2 || ctl_rd || dport_hit)
            pending <= 1'b0;
    end

    // Command code and address fields, plus the post-transfer step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd  <= '0;
            addr <= '0;
        end else begin
            if (word1) begin
                cmd[1:0]         <= wdata[15:14];
                addr[13:0]       <= wdata[13:0];
            end else if (word2) begin
                cmd[CMD_W-1]     <= wdata[7] && dma_en;
                cmd[CMD_W-2:2]   <= wdata[6:4];
                addr[VADR_W-1:14] <= wdata[1:0];
            end else if (step_pulse) begin
                addr <= addr + VADR_W'(step);
            end
            if (dma_kill)
                cmd[CMD_W-1] <= 1'b0;
        end
    end

    assert_first_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && !pending && wdata[15:14] != REG_WORD_TAG |=> pending && cmd[1:0] == $past(wdata[15:14]));
    assert_second_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && pending |=> !pending && addr[VADR_W-1:14] == $past(wdata[1:0]));
    assert_read_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd || dport_hit) && !ctl_wr |=> !pending);
    assert_step_adds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step_pulse && !ctl_wr |=> addr == $past(addr) + VADR_W'($past(step)));
endmodule

// File: rtl/vhp_cfg_file.sv
// Configuration file: decodes single-word register writes into mode, step and DMA settings.
// Assumes: reg_wr and word2 are never high together (both come from one control write).
module vhp_cfg_file
    import vhp_pkg::*;
#(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [15:0]       wdata,
    input  logic              word2,
    output logic [STEP_W-1:0] auto_inc,
    output logic              dma_en,
    output logic              tall,
    output logic [15:0]       dma_len,
    output logic [21:0]       dma_src,
    output logic [1:0]        dma_mode,
    output logic              dma_wait,
    output logic              dma_kill
);
    logic [REG_IDX_W-1:0] idx;
    logic [7:0]           val;
    logic [7:0]           dma_byte [DMA_BYTES];
    logic                 unused_tag_bit;

    assign idx            = wdata[12:8];
    assign val            = wdata[7:0];
    assign unused_tag_bit = wdata[13];

    // Request to drop the DMA-active command bit.
    assign dma_kill = reg_wr && idx == REG_MODE2 && !val[4];

    // Mode and step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            auto_inc <= '0;
            dma_en   <= 1'b0;
            tall     <= 1'b0;
        end else if (reg_wr) begin
            if (idx == REG_MODE2) begin
                dma_en <= val[4];
                tall   <= val[3];
            end
            if (idx == REG_AUTOINC)
                auto_inc <= val[STEP_W-1:0];
        end
    end

    // One register per consecutive DMA byte index.
    for (genvar k = 0; k < DMA_BYTES; k++) begin : g_dma_byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                dma_byte[k] <= '0;
            else if (reg_wr && idx == REG_DMA_B0 + REG_IDX_W'(k))
                dma_byte[k] <= val;
        end
    end

    assign dma_len  = {dma_byte[1], dma_byte[0]};
    assign dma_src  = {dma_byte[4][5:0], dma_byte[3], dma_byte[2]};
    assign dma_mode = dma_byte[4][7:6];

    // Wait flag: set from the mode write, dropped by a second command word in mode 3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_wait <= 1'b0;
        else if (reg_wr && idx == REG_DMA_TOP)
            dma_wait <= val[7];
        else if (word2 && dma_mode == 2'd3)
            dma_wait <= 1'b0;
    end

    assert_wait_from_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && wdata[12:8] == REG_DMA_TOP |=> dma_wait == $past(wdata[7]) && dma_mode == $past(wdata[7:6]));
    assert_wait_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        word2 && dma_mode == 2'd3 |=> !dma_wait);
endmodule

// File: rtl/vhp_host_port.sv
// Host port top: decodes the bus, forms the read data (data, status, counter),
// and joins the command assembler to the configuration file.
// Assumes: bus_rd and bus_wr are never high in the same cycle.
module vhp_host_port
    import vhp_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int V_W         = 9,
    parameter int HDOT_W      = 9,
    parameter int H_W         = 11,
    parameter int LINES_SHORT = 224,
    parameter int LINES_TALL  = 240,
    parameter int HBLANK_AT   = 1280
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [15:0]       bus_rdata,
    output logic              dport_wr,
    output logic              dport_rd,
    input  logic [15:0]       dport_rdata,
    input  logic              data_port_access,
    input  logic [V_W-1:0]    beam_v,
    input  logic [HDOT_W-1:0] beam_hdot,
    input  logic [H_W-1:0]    beam_h,
    input  logic              region_pal,
    output logic [5:0]        cmd_code,
    output logic [15:0]       vram_addr,
    output logic [7:0]        auto_inc,
    output logic              dma_enable,
    output logic              display_tall,
    output logic [1:0]        dma_mode,
    output logic              dma_wait,
    output logic [15:0]       dma_length,
    output logic [21:0]       dma_source
);
    localparam logic [V_W-1:0] V_SHORT = V_W'(LINES_SHORT);
    localparam logic [V_W-1:0] V_TALL  = V_W'(LINES_TALL);
    localparam logic [H_W-1:0] H_EDGE  = H_W'(HBLANK_AT);

    port_e       port;
    logic        ctl_wr, ctl_rd;
    logic        pending, word2, reg_wr, dma_kill;
    logic        vblank, hblank;
    logic [15:0] status_word, hv_word;
    logic        unused_hdot_lsb;

    vhp_port_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr (bus_addr),
        .port (port)
    );

    // Port strobes.
    always_comb begin
        ctl_wr   = bus_wr && port == PORT_CTRL;
        ctl_rd   = bus_rd && port == PORT_CTRL;
        dport_wr = bus_wr && port == PORT_DATA;
        dport_rd = bus_rd && port == PORT_DATA;
    end

    vhp_cmd_latch #(.CMD_W(6), .VADR_W(16), .STEP_W(8)) i_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_rd     (ctl_rd),
        .dport_hit  (dport_wr || dport_rd),
        .wdata      (bus_wdata),
        .step_pulse (data_port_access),
        .step       (auto_inc),
        .dma_en     (dma_enable),
        .dma_kill   (dma_kill),
        .cmd        (cmd_code),
        .addr       (vram_addr),
        .pending    (pending),
        .word2      (word2),
        .reg_wr     (reg_wr)
    );

    vhp_cfg_file #(.STEP_W(8)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .wdata    (bus_wdata),
        .word2    (word2),
        .auto_inc (auto_inc),
        .dma_en   (dma_enable),
        .tall     (display_tall),
        .dma_len  (dma_length),
        .dma_src  (dma_source),
        .dma_mode (dma_mode),
        .dma_wait (dma_wait),
        .dma_kill (dma_kill)
    );

    // Blanking flags and the two computed read words.
    always_comb begin
        vblank      = beam_v >= (display_tall ? V_TALL : V_SHORT);
        hblank      = beam_h >= H_EDGE;
        status_word = STATUS_BASE | {12'd0, vblank, hblank, cmd_code[5], region_pal};
        hv_word     = {beam_v[7:0], beam_hdot[8:1]};
    end
    assign unused_hdot_lsb = beam_hdot[0];

    // Registered read data, loaded on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd) begin
            case (port)
                PORT_DATA: bus_rdata <= dport_rdata;
                PORT_CTRL: bus_rdata <= status_word;
                PORT_HV:   bus_rdata <= hv_word;
                default:   bus_rdata <= '0;
            endcase
        end
    end

    assert_dma_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_enable |-> !cmd_code[5]);
    assert_status_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && port == PORT_CTRL |=> bus_rdata[15:8] == 8'h36);
    assert_unmapped_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && port == PORT_NONE |=> bus_rdata == 16'h0000);
endmodule

// File: tb/test_vhp_host_port.sv
// Directed bench for the host port: one task per scenario, each checking its own results.
module test_vhp_host_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        dport_wr, dport_rd;
    logic [15:0] dport_rdata = '0;
    logic        data_port_access = 1'b0;
    logic [8:0]  beam_v = '0, beam_hdot = '0;
    logic [10:0] beam_h = '0;
    logic        region_pal = 1'b0;
    logic [5:0]  cmd_code;
    logic [15:0] vram_addr;
    logic [7:0]  auto_inc;
    logic        dma_enable, display_tall, dma_wait;
    logic [1:0]  dma_mode;
    logic [15:0] dma_length;
    logic [21:0] dma_source;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    vhp_host_port i_vhp_host_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .dport_wr(dport_wr), .dport_rd(dport_rd), .dport_rdata(dport_rdata),
        .data_port_access(data_port_access), .beam_v(beam_v), .beam_hdot(beam_hdot),
        .beam_h(beam_h), .region_pal(region_pal), .cmd_code(cmd_code),
        .vram_addr(vram_addr), .auto_inc(auto_inc), .dma_enable(dma_enable),
        .display_tall(display_tall), .dma_mode(dma_mode), .dma_wait(dma_wait),
        .dma_length(dma_length), .dma_source(dma_source)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
        $finish;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [23:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [23:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ctl(input logic [15:0] d);
        wr(24'hC00004, d);
    endtask

    task automatic step_pulse();
        @(negedge clk);
        data_port_access = 1'b1;
        @(negedge clk);
        data_port_access = 1'b0;
    endtask

    task automatic t_reset();
        check("R13 cmd_code reset", cmd_code, 0);
        check("R13 vram_addr reset", vram_addr, 0);
        check("R13 cfg reset", {auto_inc, dma_enable, display_tall, dma_mode, dma_wait}, 0);
        check("R13 dma reset", {dma_length, dma_source}, 0);
        check("R13 rdata reset", bus_rdata, 0);
    endtask

    task automatic t_command_pair();
        ctl(16'h4123);
        check("R3 first word cmd", cmd_code, 6'h01);
        check("R3 first word addr", vram_addr, 16'h0123);
        ctl(16'h0073);
        check("R4 second word cmd", cmd_code, 6'h1D);
        check("R4 second word addr", vram_addr, 16'hC123);
        ctl(16'h8F02);
        check("R4 pending cleared", auto_inc, 8'h02);
    endtask

    task automatic t_register_words();
        ctl(16'h8F04);
        check("R5 reg write", auto_inc, 8'h04);
        ctl(16'hAF07);
        check("R5 bit13 ignored", auto_inc, 8'h07);
        ctl(16'h8855);
        check("R5 unused index", {auto_inc, dma_enable, display_tall, dma_length}, {8'h07, 2'b00, 16'h0000});
        ctl(16'h4000);
        ctl(16'h8F09);
        check("R5 tagged word while pending keeps step", auto_inc, 8'h07);
        check("R5 tagged word while pending is word two", vram_addr, 16'h4000);
    endtask

    task automatic t_step();
        step_pulse();
        check("R6 step", vram_addr, 16'h4007);
        ctl(16'h7FFE);
        ctl(16'h0003);
        check("R6 setup", vram_addr, 16'hFFFE);
        step_pulse();
        check("R6 wrap", vram_addr, 16'h0005);
    endtask

    task automatic t_dma_regs();
        ctl(16'h9334); ctl(16'h9412);
        check("R7 length", dma_length, 16'h1234);
        ctl(16'h95AB); ctl(16'h96CD); ctl(16'h97BF);
        check("R7 source", dma_source, 22'h3FCDAB);
        check("R7 mode and wait", {dma_mode, dma_wait}, 3'b101);
        ctl(16'h9740);
        check("R7 mode1 wait low", {dma_mode, dma_wait, dma_source[21:16]}, {2'b01, 1'b0, 6'h00});
    endtask

    task automatic t_wait_clear();
        ctl(16'h97C5);
        check("R9 setup mode3", {dma_mode, dma_wait}, 3'b111);
        ctl(16'h4000); ctl(16'h0000);
        check("R9 mode3 clears wait", dma_wait, 0);
        ctl(16'h9780);
        ctl(16'h4000); ctl(16'h0000);
        check("R9 mode2 keeps wait", dma_wait, 1);
    endtask

    task automatic t_dma_gate();
        logic [15:0] d;
        ctl(16'h8110);
        check("R8 enable", {dma_enable, display_tall}, 2'b10);
        ctl(16'h4000); ctl(16'h0080);
        check("R8 active bit set", cmd_code, 6'h21);
        beam_v = 0; beam_h = 0; region_pal = 0;
        rd(24'hC00006, d);
        check("R10 status dma active", d, 16'h3602);
        ctl(16'h8108);
        check("R8 disable clears", cmd_code, 6'h01);
        check("R8 tall bit", {dma_enable, display_tall}, 2'b01);
        ctl(16'h4000); ctl(16'h0080);
        check("R8 gated second word", cmd_code, 6'h01);
    endtask

    task automatic t_blanking();
        logic [15:0] d;
        beam_v = 239; beam_h = 1279; region_pal = 1;
        rd(24'hC00004, d);
        check("R11 below edges tall", d, 16'h3601);
        beam_v = 240; beam_h = 1280;
        rd(24'hC00004, d);
        check("R11 at edges tall", d, 16'h360D);
        ctl(16'h8100);
        beam_v = 224; beam_h = 0; region_pal = 0;
        rd(24'hC00004, d);
        check("R11 short vblank", d, 16'h3608);
        beam_v = 223;
        rd(24'hC00004, d);
        check("R10 idle status", d, 16'h3600);
    endtask

    task automatic t_counter();
        logic [15:0] d;
        beam_v = 9'h1AB; beam_hdot = 9'h155;
        rd(24'hC0000E, d);
        check("R2 counter read", d, 16'hABAA);
        rd(24'hFFFFE8, d);
        check("R1 mirrored counter", d, 16'hABAA);
        wr(24'hC00008, 16'h4000);
        ctl(16'h8F03);
        check("R2 counter write ignored", auto_inc, 8'h03);
        beam_v = 0; beam_hdot = 0;
    endtask

    task automatic t_decode();
        logic [15:0] d;
        rd(24'hC00010, d);
        check("R1 bit4 unmapped", d, 16'h0000);
        rd(24'hC00005, d);
        check("R1 odd control", d, 16'h3600);
        ctl(16'h4000);
        rd(24'h800004, d);
        check("R1 low bit22 unmapped", d, 16'h0000);
        ctl(16'h0010);
        check("R1 unmapped read kept pending", cmd_code, 6'h05);
    endtask

    task automatic t_pending_clear();
        logic [15:0] d;
        ctl(16'h4000);
        rd(24'hC00004, d);
        ctl(16'h8F05);
        check("R12 control read clears", auto_inc, 8'h05);
        ctl(16'h4000);
        @(negedge clk);
        bus_addr = 24'hC00000; bus_wdata = 16'h1111; bus_wr = 1'b1;
        #1 check("R12 dport_wr pass", {dport_wr, dport_rd}, 2'b10);
        @(negedge clk);
        bus_wr = 1'b0;
        ctl(16'h8F06);
        check("R12 data write clears", auto_inc, 8'h06);
        dport_rdata = 16'hBEEF;
        @(negedge clk);
        bus_addr = 24'hC00002; bus_rd = 1'b1;
        #1 check("R12 dport_rd pass", {dport_wr, dport_rd}, 2'b01);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R12 data read value", bus_rdata, 16'hBEEF);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_command_pair();
        t_register_words();
        t_step();
        t_dma_regs();
        t_wait_clear();
        t_dma_gate();
        t_blanking();
        t_counter();
        t_decode();
        t_pending_clear();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end
endmodule